// File: doc/BRIEF.md
# PWM Timer Channel with Double-Buffered Compare and Reload

This block is a single-channel pulse-width timer. An internal counter runs up or down between zero and a reload limit, and one output-compare channel turns the counter value into a reference waveform and then into an output pin. Software gives the reload limit and the compare threshold through plain write strobes. Each write lands in a staging copy. The copies that the counter and the comparator use change only on an update event, so a new period or duty cycle never takes effect partway through a period.

An update event occurs when the counter wraps, or when software pulses a force-update strobe. Software normally writes both staging copies and pulses that strobe while the counter is stopped, then enables counting. The channel has a hold mode that keeps the reference at its last value and two PWM modes, one the inverse of the other. A polarity bit sets the active level and an enable bit parks the pin at its inactive level. With a reload limit of N the period is N+1 counts. For example, a limit of 8 with a threshold of 4, counting up in PWM mode 1, gives 4 active counts out of 9.

Top module: `pwm_compare_timer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `cnt_q`, `upd_evt`, `pwm_ref` and `pwm_out` are 0. Both staging copies and both working copies reset to 0.
- R2: A write with `arr_wr` or `cmp_wr` changes only the staging copy. The counter's wrap point and the compare result keep using the old working value until the next update event. On that event, both working copies take the staging values held before the edge.
- R3: A `ug_strobe` pulse causes an update event. On the same edge the counter loads 0 when `dir_down`=0, or the newly staged reload value when `dir_down`=1. `upd_evt` is high in the following cycle.
- R4: With `cnt_en`=1 and `dir_down`=0, the counter counts up and wraps from the working reload value to 0. With `dir_down`=1 it counts down and wraps from 0 to the staged reload value. Each wrap is an update event and sets `upd_evt` for one cycle, in the same cycle as the wrapped count.
- R5: In PWM mode 1 (`oc_mode`=3'b110) with `dir_down`=0, the reference is 1 while count < compare and 0 otherwise. A compare value of 0 holds the reference at 0.
- R6: In PWM mode 1 with `dir_down`=1, the reference is 0 while count > compare and 1 otherwise. A compare value of 0 therefore still gives one active count per period.
- R7: In PWM mode 1, a compare value greater than the reload value holds the reference at 1 in both directions.
- R8: PWM mode 2 (`oc_mode`=3'b111) gives the inverse of the mode 1 reference under the same conditions.
- R9: In hold mode (`oc_mode`=3'b000, and any code other than 3'b110 or 3'b111), the reference keeps its last value. After a switch into a PWM mode, the reference takes the newly computed value on the next edge.
- R10: With `out_en`=1, `pwm_out` equals `pwm_ref` when `pol_low`=0 and the inverse of `pwm_ref` when `pol_low`=1.
- R11: With `out_en`=0, `pwm_out` drives the inactive level, which equals `pol_low`.
- R12: `pwm_ref` and `pwm_out` are registered. In each cycle they reflect the count, the working values and the control inputs of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counter run enable |
| dir_down | input | 1 | 0 counts up, 1 counts down |
| ug_strobe | input | 1 | Force an update event |
| arr_wr | input | 1 | Write strobe for the staged reload value |
| arr_wdata | input | CNT_W | Reload value to stage |
| cmp_wr | input | 1 | Write strobe for the staged compare value |
| cmp_wdata | input | CNT_W | Compare value to stage |
| oc_mode | input | 3 | 000 hold, 110 PWM mode 1, 111 PWM mode 2 |
| pol_low | input | 1 | 1 makes the active level low |
| out_en | input | 1 | Output enable |
| cnt_q | output | CNT_W | Current counter value |
| upd_evt | output | 1 | Registered update-event pulse |
| pwm_ref | output | 1 | Registered reference waveform |
| pwm_out | output | 1 | Registered output pin |

## Verification
The bench builds the block with CNT_W=8. This keeps every period short, so each vector can run a complete period and count its active cycles directly. The short periods also let the bench reach the saturation cases, in which the compare value is 0 or is one above the reload value, in both directions within a few dozen cycles. The same width lets the directed tests watch a staged reload value wait for the next wrap, and follow a hold-mode reference through a forced update and back into PWM mode.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

  localparam int MODE_W = 3;

  localparam logic [MODE_W-1:0] OCM_HOLD = 3'b000;
  localparam logic [MODE_W-1:0] OCM_PWM1 = 3'b110;
  localparam logic [MODE_W-1:0] OCM_PWM2 = 3'b111;

  // index of each double-buffered value inside the buffer bank
  localparam int BUF_ARR = 0;
  localparam int BUF_CMP = 1;
  localparam int BUF_N   = 2;

  typedef enum logic [1:0] {
    REF_HOLD = 2'd0,
    REF_PWM1 = 2'd1,
    REF_PWM2 = 2'd2
  } ref_sel_t;

  function automatic ref_sel_t decode_mode(input logic [MODE_W-1:0] m);
    ref_sel_t s;
    case (m)
      OCM_PWM1: s = REF_PWM1;
      OCM_PWM2: s = REF_PWM2;
      default:  s = REF_HOLD;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/pwmt_dbuf.sv
// One staged/working register pair. The working copy loads the staged copy
// as it stood before the edge of an update event.
module pwmt_dbuf #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         load,
  output logic [W-1:0] stage_q,
  output logic [W-1:0] work_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      work_q  <= '0;
    end else begin
      if (wr) begin
        stage_q <= wdata;
      end
      if (load) begin
        work_q <= stage_q;
      end
    end
  end

endmodule

// File: rtl/pwmt_counter.sv
// Up/down counter. Produces the update event and its registered pulse.
module pwmt_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         down,
  input  logic         force_upd,
  input  logic [W-1:0] lim_work,
  input  logic [W-1:0] lim_stage,
  output logic [W-1:0] cnt_q,
  output logic         uev,
  output logic         uev_q
);

  logic at_top;
  logic at_bottom;
  logic wrap;

  always_comb begin
    at_top    = (cnt_q >= lim_work);
    at_bottom = (cnt_q == '0);
    wrap      = down ? at_bottom : at_top;
    uev       = force_upd | (run & wrap);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      uev_q <= 1'b0;
    end else begin
      uev_q <= uev;
      if (force_upd) begin
        cnt_q <= down ? lim_stage : '0;
      end else if (run) begin
        if (down) begin
          cnt_q <= at_bottom ? lim_stage : cnt_q - 1'b1;
        end else begin
          cnt_q <= at_top ? '0 : cnt_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pwmt_oc_channel.sv
// Compare logic, reference register, polarity and output gating.
module pwmt_oc_channel
  import pwmt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      cnt,
  input  logic [W-1:0]      cmp_work,
  input  logic [W-1:0]      lim_work,
  input  logic              down,
  input  logic [MODE_W-1:0] mode,
  input  logic              pol_low,
  input  logic              out_en,
  output logic              ref_q,
  output logic              pin_q
);

  ref_sel_t sel;
  logic     cmp_above_lim;
  logic     mode1_val;
  logic     ref_next;

  always_comb begin
    sel           = decode_mode(mode);
    cmp_above_lim = (cmp_work > lim_work);
    if (cmp_above_lim) begin
      mode1_val = 1'b1;
    end else if (down) begin
      mode1_val = (cnt <= cmp_work);
    end else if (cmp_work == '0) begin
      mode1_val = 1'b0;
    end else begin
      mode1_val = (cnt < cmp_work);
    end
    case (sel)
      REF_PWM1: ref_next = mode1_val;
      REF_PWM2: ref_next = ~mode1_val;
      default:  ref_next = ref_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= 1'b0;
      pin_q <= 1'b0;
    end else begin
      ref_q <= ref_next;
      pin_q <= out_en ? (ref_next ^ pol_low) : pol_low;
    end
  end

endmodule

// File: rtl/pwm_compare_timer.sv
module pwm_compare_timer
  import pwmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en,
  input  logic              dir_down,
  input  logic              ug_strobe,
  input  logic              arr_wr,
  input  logic [CNT_W-1:0]  arr_wdata,
  input  logic              cmp_wr,
  input  logic [CNT_W-1:0]  cmp_wdata,
  input  logic [MODE_W-1:0] oc_mode,
  input  logic              pol_low,
  input  logic              out_en,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              upd_evt,
  output logic              pwm_ref,
  output logic              pwm_out
);

  logic                 uev;
  logic [BUF_N-1:0]     buf_wr;
  logic [CNT_W-1:0]     buf_wdata [BUF_N];
  logic [CNT_W-1:0]     buf_stage [BUF_N];
  logic [CNT_W-1:0]     buf_work  [BUF_N];
  logic [CNT_W-1:0]     arr_pre, arr_sh, cmp_pre, cmp_sh;

  always_comb begin
    buf_wr[BUF_ARR]    = arr_wr;
    buf_wr[BUF_CMP]    = cmp_wr;
    buf_wdata[BUF_ARR] = arr_wdata;
    buf_wdata[BUF_CMP] = cmp_wdata;
    arr_pre            = buf_stage[BUF_ARR];
    arr_sh             = buf_work[BUF_ARR];
    cmp_pre            = buf_stage[BUF_CMP];
    cmp_sh             = buf_work[BUF_CMP];
  end

  for (genvar i = 0; i < BUF_N; i++) begin : g_buf
    pwmt_dbuf #(.W(CNT_W)) u_dbuf (
      .clk     (clk),
      .rst     (rst),
      .wr      (buf_wr[i]),
      .wdata   (buf_wdata[i]),
      .load    (uev),
      .stage_q (buf_stage[i]),
      .work_q  (buf_work[i])
    );
  end

  pwmt_counter #(.W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .run       (cnt_en),
    .down      (dir_down),
    .force_upd (ug_strobe),
    .lim_work  (arr_sh),
    .lim_stage (arr_pre),
    .cnt_q     (cnt_q),
    .uev       (uev),
    .uev_q     (upd_evt)
  );

  pwmt_oc_channel #(.W(CNT_W)) u_oc (
    .clk      (clk),
    .rst      (rst),
    .cnt      (cnt_q),
    .cmp_work (cmp_sh),
    .lim_work (arr_sh),
    .down     (dir_down),
    .mode     (oc_mode),
    .pol_low  (pol_low),
    .out_en   (out_en),
    .ref_q    (pwm_ref),
    .pin_q    (pwm_out)
  );

endmodule

// File: rtl/pwmt_checker.sv
module pwmt_checker
  import pwmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cnt_en,
  input logic              dir_down,
  input logic              ug_strobe,
  input logic [MODE_W-1:0] oc_mode,
  input logic              pol_low,
  input logic              out_en,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              upd_evt,
  input logic              pwm_ref,
  input logic              pwm_out,
  input logic [CNT_W-1:0]  arr_pre,
  input logic [CNT_W-1:0]  arr_sh,
  input logic [CNT_W-1:0]  cmp_pre,
  input logic [CNT_W-1:0]  cmp_sh
);

  a_r2_shadow_load: assert property (@(posedge clk) disable iff (rst)
    upd_evt |-> (arr_sh == $past(arr_pre)) && (cmp_sh == $past(cmp_pre)));

  a_r2_shadow_hold: assert property (@(posedge clk) disable iff (rst)
    !upd_evt |-> $stable(arr_sh) && $stable(cmp_sh));

  a_r3_ug_zero: assert property (@(posedge clk) disable iff (rst)
    (ug_strobe && !dir_down) |=> (cnt_q == '0));

  a_r3_ug_pulse: assert property (@(posedge clk) disable iff (rst)
    ug_strobe |=> upd_evt);

  a_r4_up_wrap: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !ug_strobe && !dir_down && (cnt_q >= arr_sh)) |=> (cnt_q == '0) && upd_evt);

  a_r5_zero_low: assert property (@(posedge clk) disable iff (rst)
    ((oc_mode == OCM_PWM1) && !dir_down && (cmp_sh == '0)) |=> !pwm_ref);

  a_r7_sat_high: assert property (@(posedge clk) disable iff (rst)
    ((oc_mode == OCM_PWM1) && (cmp_sh > arr_sh)) |=> pwm_ref);

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (oc_mode == OCM_HOLD) |=> $stable(pwm_ref));

  a_r10_polarity: assert property (@(posedge clk) disable iff (rst)
    out_en |=> (pwm_out == (pwm_ref ^ $past(pol_low))));

  a_r11_disabled: assert property (@(posedge clk) disable iff (rst)
    !out_en |=> (pwm_out == $past(pol_low)));

endmodule

bind pwm_compare_timer pwmt_checker #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .cnt_en    (cnt_en),
  .dir_down  (dir_down),
  .ug_strobe (ug_strobe),
  .oc_mode   (oc_mode),
  .pol_low   (pol_low),
  .out_en    (out_en),
  .cnt_q     (cnt_q),
  .upd_evt   (upd_evt),
  .pwm_ref   (pwm_ref),
  .pwm_out   (pwm_out),
  .arr_pre   (arr_pre),
  .arr_sh    (arr_sh),
  .cmp_pre   (cmp_pre),
  .cmp_sh    (cmp_sh)
);

// File: tb/pwm_compare_timer_tb_top.sv
module pwm_compare_timer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int WATCHDOG = 20000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cnt_en = 1'b0, dir_down = 1'b0, ug_strobe = 1'b0;
  logic         arr_wr = 1'b0, cmp_wr = 1'b0;
  logic [W-1:0] arr_wdata = '0, cmp_wdata = '0;
  logic [2:0]   oc_mode = 3'b000;
  logic         pol_low = 1'b0, out_en = 1'b0;
  logic [W-1:0] cnt_q;
  logic         upd_evt, pwm_ref, pwm_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_compare_timer #(.CNT_W(W)) dut_i (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .dir_down(dir_down),
    .ug_strobe(ug_strobe), .arr_wr(arr_wr), .arr_wdata(arr_wdata),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .oc_mode(oc_mode),
    .pol_low(pol_low), .out_en(out_en), .cnt_q(cnt_q), .upd_evt(upd_evt),
    .pwm_ref(pwm_ref), .pwm_out(pwm_out)
  );

  typedef struct packed {
    logic       dir;
    logic [2:0] mode;
    logic       pol;
    logic       en;
    logic [7:0] arr;
    logic [7:0] cmp;
    logic [7:0] hi;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'b110, 1'b0, 1'b1, 8'd8, 8'd4, 8'd4, 8'd5},  // R5 4 of 9
    '{1'b0, 3'b110, 1'b0, 1'b1, 8'd8, 8'd0, 8'd0, 8'd5},  // R5 zero holds 0
    '{1'b0, 3'b110, 1'b0, 1'b1, 8'd8, 8'd8, 8'd8, 8'd5},  // R5 cmp = arr
    '{1'b0, 3'b110, 1'b0, 1'b1, 8'd8, 8'd9, 8'd9, 8'd7},  // R7 up saturate
    '{1'b1, 3'b110, 1'b0, 1'b1, 8'd8, 8'd4, 8'd5, 8'd6},  // R6 down
    '{1'b1, 3'b110, 1'b0, 1'b1, 8'd8, 8'd0, 8'd1, 8'd6},  // R6 no 0 percent
    '{1'b1, 3'b110, 1'b0, 1'b1, 8'd8, 8'd9, 8'd9, 8'd7},  // R7 down saturate
    '{1'b0, 3'b111, 1'b0, 1'b1, 8'd8, 8'd4, 8'd5, 8'd8},  // R8 inverse
    '{1'b0, 3'b110, 1'b1, 1'b1, 8'd8, 8'd4, 8'd5, 8'd10}, // R10 active low
    '{1'b0, 3'b110, 1'b0, 1'b0, 8'd8, 8'd4, 8'd0, 8'd11}, // R11 idle low
    '{1'b0, 3'b110, 1'b1, 1'b0, 8'd8, 8'd4, 8'd9, 8'd11}, // R11 idle high
    '{1'b0, 3'b110, 1'b0, 1'b1, 8'd3, 8'd1, 8'd1, 8'd5}   // R5 short period
  };

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load_cfg(input logic [W-1:0] a, input logic [W-1:0] c);
    cnt_en = 1'b0;
    arr_wr = 1'b1; arr_wdata = a;
    cmp_wr = 1'b1; cmp_wdata = c;
    cyc();
    arr_wr = 1'b0; cmp_wr = 1'b0;
    ug_strobe = 1'b1;
    cyc();
    ug_strobe = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int hi;
    int mx;
    repeat (3) cyc();
    // R1 reset state during and after reset
    check("R1 cnt in reset", cnt_q, 0);
    check("R1 out in reset", {upd_evt, pwm_ref, pwm_out}, 0);
    rst = 1'b0;
    cyc();
    check("R1 cnt after reset", cnt_q, 0);
    check("R1 outputs after reset", {upd_evt, pwm_ref, pwm_out}, 0);

    // table walk: active cycles of pwm_out over one full period
    for (int v = 0; v < NV; v++) begin
      dir_down = VECS[v].dir;
      oc_mode  = VECS[v].mode;
      pol_low  = VECS[v].pol;
      out_en   = VECS[v].en;
      load_cfg(VECS[v].arr, VECS[v].cmp);
      cnt_en = 1'b1;
      repeat (3) cyc();
      hi = 0;
      for (int k = 0; k <= int'(VECS[v].arr); k++) begin
        cyc();
        if (pwm_out) hi++;
      end
      check($sformatf("vector %0d (R%0d) R12 high count", v, VECS[v].req), hi, VECS[v].hi);
    end

    // R3 forced update while counting up: counter to 0, pulse next cycle
    dir_down = 1'b0; oc_mode = 3'b110; pol_low = 1'b0; out_en = 1'b1;
    load_cfg(8'd8, 8'd4);
    check("R3 ug clears count", cnt_q, 0);
    check("R3 ug pulse", upd_evt, 1);
    cyc();
    check("R3 pulse one cycle", upd_evt, 0);

    // R3 forced update counting down loads newly staged limit
    dir_down = 1'b1;
    load_cfg(8'd5, 8'd2);
    check("R3 ug down loads limit", cnt_q, 5);

    // R4 down wrap from 0 to limit with pulse
    cnt_en = 1'b1;
    repeat (5) cyc();
    check("R4 down reached zero", cnt_q, 0);
    cyc();
    check("R4 down wrap value", cnt_q, 5);
    check("R4 down wrap pulse", upd_evt, 1);

    // R4 up wrap from limit to 0 with pulse
    dir_down = 1'b0;
    load_cfg(8'd4, 8'd2);
    cnt_en = 1'b1;
    repeat (4) cyc();
    check("R4 up at limit", cnt_q, 4);
    check("R4 no pulse before wrap", upd_evt, 0);
    cyc();
    check("R4 up wrap value", cnt_q, 0);
    check("R4 up wrap pulse", upd_evt, 1);

    // R2 staged limit waits for the next wrap
    load_cfg(8'd8, 8'd4);
    arr_wr = 1'b1; arr_wdata = 8'd3;
    cyc();
    arr_wr = 1'b0;
    cnt_en = 1'b1;
    mx = 0;
    for (int k = 0; k < 9; k++) begin
      cyc();
      if (int'(cnt_q) > mx) mx = cnt_q;
    end
    check("R2 old limit kept until update", mx, 8);
    mx = 0;
    for (int k = 0; k < 8; k++) begin
      cyc();
      if (int'(cnt_q) > mx) mx = cnt_q;
    end
    check("R2 new limit after wrap", mx, 3);

    // R9 hold mode keeps reference through a forced update
    oc_mode = 3'b110;
    load_cfg(8'd8, 8'd9);
    cnt_en = 1'b1;
    repeat (2) cyc();
    check("R9 reference before hold", pwm_ref, 1);
    oc_mode = 3'b000;
    load_cfg(8'd8, 8'd0);
    cnt_en = 1'b1;
    repeat (3) cyc();
    check("R9 hold keeps value", pwm_ref, 1);
    oc_mode = 3'b110;
    cyc();
    check("R9 leave hold re-evaluates", pwm_ref, 0);

    // R10 polarity flip seen on the next edge
    load_cfg(8'd8, 8'd9);
    cnt_en = 1'b1;
    pol_low = 1'b1;
    cyc();
    check("R10 active low inverts", pwm_out, 0);
    pol_low = 1'b0;
    cyc();
    check("R10 active high follows", pwm_out, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule